// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Front End

This block is the digital front end of a four-channel digital-to-analog converter that hangs off an asynchronous parallel bus. A host drives a channel address and a data word, asserts chip select, and pulses the active-low write strobe. When the strobe returns high, the word is latched into the addressed channel's input register. The outputs do not move at that point. A separate active-low load control copies every input register into its DAC register in the same clock cycle. This lets a host stage new values on all four channels and then update them together.

Bus strobes and mode pins are brought into the system clock domain through two-flop synchronizers. The rising edge of the synchronized write strobe becomes a single-cycle capture pulse. An asynchronous active-low clear zeroes both register banks at once. Power-on reset leaves every output at zero until data has been written and loaded. Gain-select and power-down inputs are synchronized and passed on to the analog stage as control bits. Neither of them touches the stored codes. The data width is a parameter and may be 8, 10 or 12 bits.

Top module: `quad_dac_regs`

## Requirements
- R1: After `rst_ni` is released, `dac_o` is all zeros. It stays zero until at least one write has been captured and then loaded. A load with no prior write leaves it zero.
- R2: A rising edge on `wr_n_i` while `cs_n_i` is low stores `data_i` in the input register of channel `addr_i`. Channel k occupies `dac_o[k*DATA_W +: DATA_W]`. The other channels keep their values.
- R3: A write strobe issued while `cs_n_i` is high changes no input register.
- R4: A captured write does not change `dac_o` until a load occurs.
- R5: While the synchronized `load_n_i` is low, all four DAC registers take their input register values in the same clock cycle. `dac_o` changes only on such a load or on a clear.
- R6: When the capture pulse and the load fall in the same cycle, the addressed channel's DAC register receives the newly written word.
- R7: Driving `clr_n_i` low zeroes every input and DAC register immediately, without waiting for a clock edge. A write strobe issued while clear is held low is lost.
- R8: `gain_o` equals `gain_i` two clock edges after it was sampled, with 0 selecting unity span and 1 selecting double span.
- R9: `pd_o` equals `pd_i` two clock edges after it was sampled. Changing `pd_i` does not alter `dac_o` or the stored codes, and writes and loads keep working while it is high.
- R10: Each rising edge of the synchronized write strobe produces a capture pulse exactly one cycle long that enables at most one channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| clr_n_i | input | 1 | Active-low asynchronous clear of both register banks |
| cs_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe; its rising edge captures data |
| load_n_i | input | 1 | Active-low simultaneous load of all DAC registers |
| addr_i | input | 2 | Channel address |
| data_i | input | DATA_W | Data word |
| gain_i | input | 1 | Span select: 0 unity, 1 double |
| pd_i | input | 1 | Power-down request |
| dac_o | output | 4*DATA_W | DAC register contents, channel 0 in the low bits |
| gain_o | output | 1 | Synchronized span select |
| pd_o | output | 1 | Synchronized power-down control |

## Verification
The checks assume three things about the inputs. First, `addr_i`, `data_i` and `cs_n_i` stay stable from before the write strobe falls until several cycles after it rises, because address and data are taken raw at the capture pulse. Second, each strobe level lasts at least one full clock period. Third, any clear pulse spans at least one rising clock edge. The stimulus changes inputs only on falling clock edges. It holds the bus fields over the whole strobe window plus a margin of four cycles, and keeps every clear low for two cycles. Random writes, with chip select either active or inactive and with or without a following load, are mixed with directed cases for reset, coincident write and load, clear during a write, and power-down.

// File: rtl/dac_pkg.sv
package dac_pkg;
  parameter int unsigned NUM_CH = 4;
  localparam int unsigned ADDR_W = $clog2(NUM_CH);

  // synchronized bus controls, packed msb first
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic load_n;
    logic gain;
    logic pd;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, load_n: 1'b1, gain: 1'b0, pd: 1'b0};
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_n_s_i,
  input  logic              cs_n_s_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] wr_en_o
);
  logic wr_n_d_q;
  logic wr_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_n_d_q <= 1'b1;
    else         wr_n_d_q <= wr_n_s_i;
  end

  // strobe end marks the capture point
  assign wr_rise = wr_n_s_i & ~wr_n_d_q & ~cs_n_s_i;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
    assign wr_en_o[k] = wr_rise & (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              wr_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o
);
  logic [DATA_W-1:0] in_q, in_nxt, dac_q;

  // same-cycle load sees the fresh word
  assign in_nxt = wr_en_i ? data_i : in_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q <= in_nxt;
      if (load_i) dac_q <= in_nxt;
    end
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import dac_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_n_i,
  input  logic                     cs_n_i,
  input  logic                     wr_n_i,
  input  logic                     load_n_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     gain_i,
  input  logic                     pd_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o,
  output logic                     gain_o,
  output logic                     pd_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_raw, ctrl_s;
  logic [NUM_CH-1:0] wr_en;
  logic              load_act;
  logic              arst_n;

  assign ctrl_raw = '{cs_n: cs_n_i, wr_n: wr_n_i, load_n: load_n_i, gain: gain_i, pd: pd_i};

  dac_sync #(.WIDTH(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_raw),
    .q_o   (ctrl_s)
  );

  dac_wr_ctrl u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_n_s_i(ctrl_s.wr_n),
    .cs_n_s_i(ctrl_s.cs_n),
    .addr_i  (addr_i),
    .wr_en_o (wr_en)
  );

  assign load_act = ~ctrl_s.load_n;
  // clear and power-on reset share the bank reset
  assign arst_n   = rst_ni & clr_n_i;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dac_chan #(.DATA_W(DATA_W)) u_ch (
      .clk_i  (clk_i),
      .arst_ni(arst_n),
      .wr_en_i(wr_en[k]),
      .load_i (load_act),
      .data_i (data_i),
      .dac_o  (dac_o[k*DATA_W +: DATA_W])
    );
  end

  assign gain_o = ctrl_s.gain;
  assign pd_o   = ctrl_s.pd;
endmodule

// File: rtl/quad_dac_regs_chk.sv
module quad_dac_regs_chk
  import dac_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     clr_n_i,
  input logic [NUM_CH*DATA_W-1:0] dac_o,
  input logic [NUM_CH-1:0]        wr_en_i,
  input logic                     load_i
);
  logic seen_wr_q, seen_upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_wr_q  <= 1'b0;
      seen_upd_q <= 1'b0;
    end else begin
      if (|wr_en_i) seen_wr_q <= 1'b1;
      if (load_i && (seen_wr_q || |wr_en_i)) seen_upd_q <= 1'b1;
    end
  end

  // R1
  pwr_on_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_upd_q |-> dac_o == '0);

  // R5
  load_only_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_n_i && $past(clr_n_i) && dac_o != $past(dac_o)) |-> $past(load_i));

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_i |-> dac_o == '0);

  // R10
  single_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_i));

  // R10
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |wr_en_i |=> !(|wr_en_i));
endmodule

bind quad_dac_regs quad_dac_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_n_i(clr_n_i),
  .dac_o  (dac_o),
  .wr_en_i(wr_en),
  .load_i (load_act)
);

// File: tb/sim_quad_dac_regs.sv
module sim_quad_dac_regs;
  localparam int DW = 12;
  localparam int NC = 4;
  localparam int TW = NC * DW;

  logic          clk = 1'b0;
  logic          rst_ni, clr_n, cs_n, wr_n, load_n, gain, pd;
  logic [1:0]    addr;
  logic [DW-1:0] data;
  logic [TW-1:0] dac_o;
  logic          gain_o, pd_o;

  logic [DW-1:0] in_m  [NC];
  logic [DW-1:0] dac_m [NC];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_dac_regs #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clr_n_i(clr_n), .cs_n_i(cs_n), .wr_n_i(wr_n),
    .load_n_i(load_n), .addr_i(addr), .data_i(data), .gain_i(gain), .pd_i(pd),
    .dac_o(dac_o), .gain_o(gain_o), .pd_o(pd_o)
  );

  function automatic logic [TW-1:0] exp_dac();
    logic [TW-1:0] v;
    for (int k = 0; k < NC; k++) v[k*DW +: DW] = dac_m[k];
    return v;
  endfunction

  task automatic chk(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [DW-1:0] d, bit sel);
    @(negedge clk);
    cs_n = ~sel; addr = 2'(ch); data = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (sel && clr_n) in_m[ch] = d;
  endtask

  task automatic ld();
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NC; k++) dac_m[k] = in_m[k];
  endtask

  task automatic wr_ld(int ch, logic [DW-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = 2'(ch); data = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    in_m[ch] = d;
    for (int k = 0; k < NC; k++) dac_m[k] = in_m[k];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; load_n = 1'b1;
    gain = 1'b0; pd = 1'b0; addr = '0; data = '0;
    for (int k = 0; k < NC; k++) begin in_m[k] = '0; dac_m[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset dac", dac_o, '0);
    chk("R8 reset gain", TW'(gain_o), '0);
    chk("R9 reset pd", TW'(pd_o), '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1: load with nothing written, then write without load
    ld();
    chk("R1 load before write", dac_o, '0);
    wr(2, 12'hABC, 1'b1);
    chk("R1 R4 write without load", dac_o, '0);
    ld();
    chk("R2 R5 first load", dac_o, exp_dac());

    // R2/R5: stage all channels then a single simultaneous load
    for (int k = 0; k < NC; k++) wr(k, DW'(12'h111 * (k + 1)), 1'b1);
    chk("R4 staged, outputs unchanged", dac_o, exp_dac());
    ld();
    chk("R5 all channels together", dac_o, exp_dac());

    // R3: deselected write
    wr(1, 12'h5A5, 1'b0);
    ld();
    chk("R3 deselected write ignored", dac_o, exp_dac());

    // R6: write and load in the same cycle
    wr_ld(3, 12'hFFF);
    chk("R6 coincident write and load", dac_o, exp_dac());
    wr_ld(0, 12'h000);
    chk("R6 coincident zero word", dac_o, exp_dac());

    // R8/R9: controls pass through, codes untouched
    @(negedge clk);
    gain = 1'b1; pd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 gain high", TW'(gain_o), TW'(1));
    chk("R9 pd high", TW'(pd_o), TW'(1));
    chk("R9 pd keeps codes", dac_o, exp_dac());
    wr_ld(1, 12'h321);
    chk("R9 update during pd", dac_o, exp_dac());
    @(negedge clk);
    gain = 1'b0; pd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 gain low", TW'(gain_o), '0);
    chk("R9 pd low keeps codes", dac_o, exp_dac());

    // R7: asynchronous clear
    @(negedge clk);
    #3 clr_n = 1'b0;
    #1 chk("R7 clear immediate", dac_o, '0);
    for (int k = 0; k < NC; k++) begin in_m[k] = '0; dac_m[k] = '0; end
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    ld();
    chk("R7 input bank cleared", dac_o, '0);

    // R7: clear dominates a write
    wr(2, 12'h777, 1'b1);
    @(negedge clk);
    clr_n = 1'b0;
    for (int k = 0; k < NC; k++) begin in_m[k] = '0; dac_m[k] = '0; end
    wr(1, 12'h999, 1'b1);
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    ld();
    chk("R7 clear beats write", dac_o, '0);

    // random traffic
    for (int i = 0; i < 60; i++) begin
      int ch = int'($urandom_range(0, NC - 1));
      logic [DW-1:0] d = DW'($urandom);
      bit sel = ($urandom_range(0, 3) != 0);
      wr(ch, d, sel);
      chk(sel ? "R4 random staged" : "R3 random deselect", dac_o, exp_dac());
      if ($urandom_range(0, 1) == 1) begin
        ld();
        chk("R2 R5 random load", dac_o, exp_dac());
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule